// File: doc/BRIEF.md
# Register alias table renamer

This block keeps, for every architectural register, the reorder-buffer slot of the youngest in-flight micro-op that will write it. It sits between decode and the scheduling structures. When a micro-op is renamed, each source register is resolved in the same cycle. The result is either "read the committed register file" or the reorder-buffer tag of the producer that will supply the value. If the micro-op writes a register, its own reorder-buffer tag, handed over by the allocator, becomes the new mapping for its destination.

A commit port retires one register-writing micro-op per cycle. The mapping for that register is dropped only if it still names the retiring slot, so a younger remap of the same register survives. A flush input returns every register to the committed file in one cycle and discards speculative mappings. The register values, the committed register file and the tag allocation live outside this block.

Top module: `reg_alias_table`

## Requirements
- R1: After reset every source lookup reports the committed file: `ren_src_arch_o` bit is 1.
- R2: A source whose register has no in-flight writer reports `ren_src_arch_o` = 1.
- R3: After a rename with `ren_valid_i`=1 and `ren_dst_we_i`=1, a later lookup of that destination reports `ren_src_arch_o`=0 and `ren_src_tag_o` equal to the `ren_tag_i` it was given.
- R4: A second write to the same register replaces the mapping, so lookups return the newest tag.
- R5: A source that equals the destination of the same micro-op resolves to the mapping held before that micro-op.
- R6: A rename with `ren_valid_i`=0, or with `ren_dst_we_i`=0, leaves every mapping unchanged.
- R7: A commit (`cmt_valid_i`=1) whose `cmt_tag_i` equals the current tag of register `cmt_dst_i` clears that mapping from the next cycle on.
- R8: A commit whose tag differs from the current mapping of `cmt_dst_i` leaves that mapping unchanged.
- R9: When rename and commit address the same register in one cycle, the rename result is kept even if the commit tag matches the old mapping.
- R10: A lookup made in the cycle that commits the very mapping it would return reports the committed file instead.
- R11: `flush_i` clears every mapping in one cycle and overrides any rename or commit in that cycle.
- R12: Each source port resolves independently of the others in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ren_valid_i | input | 1 | A micro-op is being renamed |
| ren_src_i | input | NUM_SRC*AW | Source register indices, source 0 in the low bits |
| ren_dst_we_i | input | 1 | The micro-op writes a destination register |
| ren_dst_i | input | AW | Destination register index |
| ren_tag_i | input | TAG_W | Reorder-buffer slot of the micro-op |
| ren_src_arch_o | output | NUM_SRC | 1: read committed file, 0: wait on tag |
| ren_src_tag_o | output | NUM_SRC*TAG_W | Producer tag per source, valid when the arch bit is 0 |
| cmt_valid_i | input | 1 | A register-writing micro-op retires |
| cmt_dst_i | input | AW | Destination of the retiring micro-op |
| cmt_tag_i | input | TAG_W | Reorder-buffer slot of the retiring micro-op |
| flush_i | input | 1 | Drop all speculative mappings |

## Verification
The bench builds the default configuration: eight registers, a 4-bit tag and two sources. With only sixteen tags, random traffic reuses tag values quickly. Stale commits therefore often carry the same tag as a live mapping on another register or on the same one. This exercises the tag compare and the rename-over-commit priority. Random commits half the time carry the live tag of their register, so clears, stale commits, commit-time lookups and occasional flushes all occur many times.

// File: rtl/rat_pkg.sv
package rat_pkg;
  parameter int unsigned RAT_ARCH_REGS = 8;
  parameter int unsigned RAT_TAG_W     = 4;
  parameter int unsigned RAT_NUM_SRC   = 2;

  typedef enum logic {
    LOC_ROB = 1'b0,
    LOC_ARF = 1'b1
  } src_loc_e;
endpackage

// File: rtl/rat_entry.sv
module rat_entry #(
  parameter int unsigned TAG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             set_i,
  input  logic [TAG_W-1:0] set_tag_i,
  input  logic             clr_i,
  input  logic [TAG_W-1:0] clr_tag_i,
  output logic             valid_o,
  output logic [TAG_W-1:0] tag_o
);
  logic             valid_q;
  logic [TAG_W-1:0] tag_q;
  logic             tag_match;

  assign tag_match = valid_q && (tag_q == clr_tag_i);

  // flush > rename > commit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
    end else if (flush_i) begin
      valid_q <= 1'b0;
    end else if (set_i) begin
      valid_q <= 1'b1;
      tag_q   <= set_tag_i;
    end else if (clr_i && tag_match) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign tag_o   = tag_q;

  p_flush_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !valid_o);

  p_rename_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !flush_i) |=> (valid_o && tag_o == $past(set_tag_i)));

  p_commit_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && !set_i && clr_i && valid_o && tag_o == clr_tag_i) |=> !valid_o);

  p_commit_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && !set_i && !(clr_i && tag_o == clr_tag_i)) |=>
      ($stable(valid_o) && $stable(tag_o)));
endmodule

// File: rtl/rat_src_lookup.sv
module rat_src_lookup #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned TAG_W    = 4,
  localparam int unsigned AW      = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0]            map_valid_i,
  input  logic [NUM_REGS-1:0][TAG_W-1:0] map_tag_i,
  input  logic [AW-1:0]                  src_i,
  input  logic                           cmt_valid_i,
  input  logic [AW-1:0]                  cmt_dst_i,
  input  logic [TAG_W-1:0]               cmt_tag_i,
  output logic                           arch_o,
  output logic [TAG_W-1:0]               tag_o
);
  import rat_pkg::*;

  logic             hit_valid;
  logic [TAG_W-1:0] hit_tag;
  logic             retiring;
  src_loc_e         loc;

  assign hit_valid = map_valid_i[src_i];
  assign hit_tag   = map_tag_i[src_i];
  // producer retires this cycle: value lands in the committed file at this edge
  assign retiring  = cmt_valid_i && (cmt_dst_i == src_i) && (cmt_tag_i == hit_tag);

  always_comb begin
    loc = LOC_ARF;
    if (hit_valid && !retiring) loc = LOC_ROB;
  end

  assign arch_o = (loc == LOC_ARF);
  assign tag_o  = hit_tag;
endmodule

// File: rtl/reg_alias_table.sv
module reg_alias_table #(
  parameter int unsigned NUM_REGS = rat_pkg::RAT_ARCH_REGS,
  parameter int unsigned TAG_W    = rat_pkg::RAT_TAG_W,
  parameter int unsigned NUM_SRC  = rat_pkg::RAT_NUM_SRC,
  localparam int unsigned AW      = $clog2(NUM_REGS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          ren_valid_i,
  input  logic [NUM_SRC-1:0][AW-1:0]    ren_src_i,
  input  logic                          ren_dst_we_i,
  input  logic [AW-1:0]                 ren_dst_i,
  input  logic [TAG_W-1:0]              ren_tag_i,
  output logic [NUM_SRC-1:0]            ren_src_arch_o,
  output logic [NUM_SRC-1:0][TAG_W-1:0] ren_src_tag_o,
  input  logic                          cmt_valid_i,
  input  logic [AW-1:0]                 cmt_dst_i,
  input  logic [TAG_W-1:0]              cmt_tag_i,
  input  logic                          flush_i
);
  logic [NUM_REGS-1:0]            map_valid;
  logic [NUM_REGS-1:0][TAG_W-1:0] map_tag;
  logic                           ren_write;

  assign ren_write = ren_valid_i && ren_dst_we_i;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic set_r, clr_r;
    assign set_r = ren_write && (ren_dst_i == AW'(r));
    assign clr_r = cmt_valid_i && (cmt_dst_i == AW'(r));

    rat_entry #(.TAG_W(TAG_W)) i_entry (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .flush_i   (flush_i),
      .set_i     (set_r),
      .set_tag_i (ren_tag_i),
      .clr_i     (clr_r),
      .clr_tag_i (cmt_tag_i),
      .valid_o   (map_valid[r]),
      .tag_o     (map_tag[r])
    );
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    rat_src_lookup #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W)) i_lookup (
      .map_valid_i (map_valid),
      .map_tag_i   (map_tag),
      .src_i       (ren_src_i[s]),
      .cmt_valid_i (cmt_valid_i),
      .cmt_dst_i   (cmt_dst_i),
      .cmt_tag_i   (cmt_tag_i),
      .arch_o      (ren_src_arch_o[s]),
      .tag_o       (ren_src_tag_o[s])
    );
  end

  p_flush_all_arch_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (&ren_src_arch_o));

  p_new_map_seen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren_write && !flush_i) |=>
      ((ren_src_i[0] != $past(ren_dst_i)) ||
       (cmt_valid_i && cmt_dst_i == $past(ren_dst_i) && cmt_tag_i == $past(ren_tag_i)) ||
       (!ren_src_arch_o[0] && ren_src_tag_o[0] == $past(ren_tag_i))));
endmodule

// File: tb/test_reg_alias_table.sv
module test_reg_alias_table;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 8;
  localparam int TW = 4;
  localparam int NS = 2;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ren_v, ren_we, cmt_v, flush;
  logic [NS-1:0][AW-1:0] ren_src;
  logic [AW-1:0] ren_dst, cmt_d;
  logic [TW-1:0] ren_t, cmt_t;
  logic [NS-1:0] src_arch;
  logic [NS-1:0][TW-1:0] src_tag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit            mv[NR];
  logic [TW-1:0] mt[NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_alias_table i_reg_alias_table (
    .clk_i(clk), .rst_ni(rst_n),
    .ren_valid_i(ren_v), .ren_src_i(ren_src), .ren_dst_we_i(ren_we),
    .ren_dst_i(ren_dst), .ren_tag_i(ren_t),
    .ren_src_arch_o(src_arch), .ren_src_tag_o(src_tag),
    .cmt_valid_i(cmt_v), .cmt_dst_i(cmt_d), .cmt_tag_i(cmt_t),
    .flush_i(flush)
  );

  function automatic bit exp_arch(input logic [AW-1:0] r);
    return !(mv[r] && !(cmt_v && cmt_d == r && cmt_t == mt[r]));
  endfunction

  task automatic idle();
    ren_v = 0; ren_we = 0; ren_dst = '0; ren_t = '0;
    cmt_v = 0; cmt_d = '0; cmt_t = '0; flush = 0;
    ren_src[0] = '0; ren_src[1] = '0;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // inputs already driven after a falling edge; check, then clock and update model
  task automatic cycle(input string req);
    #1;
    for (int s = 0; s < NS; s++) begin
      bit ea;
      ea = exp_arch(ren_src[s]);
      chk(src_arch[s] == ea, req, int'(src_arch[s]), int'(ea));
      if (!ea) chk(src_tag[s] == mt[ren_src[s]], req, int'(src_tag[s]), int'(mt[ren_src[s]]));
    end
    @(posedge clk);
    if (flush) begin
      for (int r = 0; r < NR; r++) mv[r] = 0;
    end else begin
      for (int r = 0; r < NR; r++) begin
        if (ren_v && ren_we && ren_dst == r) begin
          mv[r] = 1; mt[r] = ren_t;
        end else if (cmt_v && cmt_d == r && mv[r] && mt[r] == cmt_t) begin
          mv[r] = 0;
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic probe(input int a, input int b, input string req);
    idle(); ren_src[0] = AW'(a); ren_src[1] = AW'(b); cmt_v = 0;
    cycle(req);
  endtask

  task automatic rename(input int d, input int t, input int a, input int b, input string req);
    idle(); ren_v = 1; ren_we = 1; ren_dst = AW'(d); ren_t = TW'(t);
    ren_src[0] = AW'(a); ren_src[1] = AW'(b);
    cycle(req);
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    for (int r = 0; r < NR; r++) begin mv[r] = 0; mt[r] = '0; end
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset: every register on the committed file
    for (int r = 0; r < NR; r++) probe(r, (r + 1) % NR, "R1");

    // R5 source equal to own destination sees prior mapping; R3 new mapping visible
    rename(1, 5, 1, 1, "R5");
    probe(1, 0, "R3");
    // R4 second write wins
    rename(1, 6, 1, 2, "R4");
    probe(1, 1, "R4");
    // R6 invalid rename and non-writing rename change nothing
    idle(); ren_v = 0; ren_we = 1; ren_dst = 3'd2; ren_t = 4'd7; cycle("R6");
    idle(); ren_v = 1; ren_we = 0; ren_dst = 3'd2; ren_t = 4'd7; cycle("R6");
    probe(2, 1, "R6");
    // R8 stale commit keeps mapping
    idle(); cmt_v = 1; cmt_d = 3'd1; cmt_t = 4'd5; cycle("R8");
    probe(1, 2, "R8");
    // R10 lookup during matching commit reports committed file
    idle(); cmt_v = 1; cmt_d = 3'd1; cmt_t = 4'd6; ren_src[0] = 3'd1; ren_src[1] = 3'd1;
    cycle("R10");
    probe(1, 3, "R7");
    // R9 rename beats matching commit on the same register
    rename(3, 9, 0, 0, "R9");
    idle(); ren_v = 1; ren_we = 1; ren_dst = 3'd3; ren_t = 4'd10;
    cmt_v = 1; cmt_d = 3'd3; cmt_t = 4'd9; cycle("R9");
    probe(3, 3, "R9");
    // R12 two sources with different producers
    rename(4, 2, 0, 0, "R12");
    rename(5, 3, 4, 3, "R12");
    probe(4, 5, "R12");
    probe(5, 4, "R12");
    // R11 flush overrides rename and commit
    idle(); flush = 1; ren_v = 1; ren_we = 1; ren_dst = 3'd6; ren_t = 4'd4;
    cmt_v = 1; cmt_d = 3'd3; cmt_t = 4'd1; cycle("R11");
    for (int r = 0; r < NR; r += 2) probe(r, r + 1, "R11");
    probe(2, 7, "R2");

    // random traffic, label by what each lookup exercises
    for (int i = 0; i < 4000; i++) begin
      string lbl;
      idle();
      ren_v = ($urandom % 4) != 0;
      ren_we = $urandom % 2;
      ren_dst = AW'($urandom);
      ren_t = TW'($urandom);
      ren_src[0] = AW'($urandom);
      ren_src[1] = AW'($urandom);
      cmt_v = $urandom % 2;
      cmt_d = AW'($urandom);
      cmt_t = ($urandom % 2) ? mt[cmt_d] : TW'($urandom);
      flush = ($urandom % 64) == 0;
      if (mv[ren_src[0]] && exp_arch(ren_src[0])) lbl = "R10";
      else if (mv[ren_src[0]]) lbl = "R4";
      else lbl = "R2";
      cycle(lbl);
    end

    finish_run();
  end
endmodule